// File: doc/BRIEF.md
# Float Immediate Constructor Unit

This unit builds a double-precision floating-point register value out of 16-bit immediates taken from an instruction word. A constant is loaded in one or two steps. The load step takes the immediate as the upper half of a single-precision word, which is the same as reading it as a bfloat16 value, and writes the double-precision equivalent. The insert step then adds 16 more bits of mantissa accuracy. It is a read-modify-write on the current register value. That value is narrowed to single precision, its low 16 bits are replaced by the immediate, and the result is widened back to double precision.

The immediate does not sit in one contiguous field of the instruction word. It is put back together from three separate fields. The unit sets no floating-point status or exception flags; it only produces a 64-bit value and a write strobe.

Neither conversion rounds. Widening re-biases the exponent and carries infinities and NaNs through unchanged. It also turns single-precision denormals into double-precision normals. Narrowing undoes that mapping exactly for every value the two operations can create.

Top module: `fimm_builder`

## Requirements
- R1: The 16-bit immediate is assembled with `imm_d0` (10 bits) as bits 15..6, `imm_d1` (5 bits) as bits 5..1 and `imm_d2` (1 bit) as bit 0.
- R2: With `op_sel` = 0 (load), the result is the double-precision value of the single-precision word {immediate, 16'h0000}. For example, 0x3F80 gives 0x3FF0_0000_0000_0000 and 0xBFC0 gives 0xBFF8_0000_0000_0000.
- R3: Widening a normal single-precision value adds 896 to the 8-bit exponent and appends 29 zero bits below the 23-bit mantissa. An all-ones exponent maps to 0x7FF with the mantissa kept, so 0x7F80 gives 0x7FF0_0000_0000_0000 and 0x7FC0 gives 0x7FF8_0000_0000_0000.
- R4: A single-precision denormal with its leading one at mantissa bit p widens to a normal double with exponent field 874+p. A zero widens to a signed zero, so 0x8000 gives 0x8000_0000_0000_0000.
- R5: With `op_sel` = 1 (insert), the result is the widened value of the narrowed register with single-precision bits 15..0 replaced by the immediate. Loading 0x3F80 and then inserting 0x8000 gives 0x3FF0_1000_0000_0000.
- R6: The insert step ignores `reg_in` bits 28..0. A register value with an exponent field below 874 narrows to a signed zero.
- R7: `res_we` is high exactly one cycle after each cycle with `in_valid` high, with `res_data` updated in that cycle. While `res_we` is low, `res_data` holds its value.
- R8: While `rst_n` is low, `res_we` is 0 and `res_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| op_sel | input | 1 | 0 = load, 1 = insert |
| imm_d0 | input | 10 | Immediate bits 15..6 |
| imm_d1 | input | 5 | Immediate bits 5..1 |
| imm_d2 | input | 1 | Immediate bit 0 |
| reg_in | input | 64 | Current register value (insert step) |
| res_we | output | 1 | Result write enable, one cycle after the request |
| res_data | output | 64 | Double-precision result |

## Verification
Loads use the documented constants (zeros of both signs, ±1.0, -1.5, ±infinity, quiet NaN, 1.9921875). These separate the exponent re-bias path from the special-exponent path and check that the sign survives. Immediates with a single low-order field bit set test each field's position and drive the denormal normalization through different leading-one positions. Inserts cover the documented two-step constant, a NaN payload, a negative value, a denormal round trip, a register with its low 29 bits set, and a double-precision denormal register. Together these show that narrowing is exact, that the ignored bits do not reach the result, and that values below the single-precision range flush to zero. Back-to-back requests and idle gaps test the one-cycle strobe and the hold behaviour.

// File: rtl/fimm_pkg.sv
package fimm_pkg;
  localparam int SP_W      = 32;
  localparam int DP_W      = 64;
  localparam int SP_EXP_W  = 8;
  localparam int SP_MAN_W  = 23;
  localparam int DP_EXP_W  = 11;
  localparam int DP_MAN_W  = 52;
  localparam int IMM_W     = 16;
  localparam int D0_W      = 10;
  localparam int D1_W      = 5;
  localparam int D2_W      = 1;
  localparam int SP_BIAS   = 127;
  localparam int DP_BIAS   = 1023;
  localparam int BIAS_DIFF = DP_BIAS - SP_BIAS;
  localparam int MAN_PAD   = DP_MAN_W - SP_MAN_W;
  localparam int SP_EXP_MAX = (1 << SP_EXP_W) - 2;
  localparam int DENORM_BASE = BIAS_DIFF + 1 - SP_MAN_W;
  localparam int KEEP_W    = 1 + DP_EXP_W + SP_MAN_W;

  typedef enum logic {OP_LOAD = 1'b0, OP_INSERT = 1'b1} fimm_op_e;

  function automatic int lead_one(input logic [SP_MAN_W-1:0] m);
    int p;
    p = 0;
    for (int i = 0; i < SP_MAN_W; i++)
      if (m[i]) p = i;
    return p;
  endfunction

  function automatic logic [DP_W-1:0] widen_sp(input logic [SP_W-1:0] w);
    logic                s;
    logic [SP_EXP_W-1:0] e;
    logic [SP_MAN_W-1:0] m;
    logic [DP_MAN_W:0]   sh;
    logic [DP_W-1:0]     r;
    int                  p;
    s = w[SP_W-1];
    e = w[SP_W-2:SP_MAN_W];
    m = w[SP_MAN_W-1:0];
    if (e == '1) begin
      r = {s, {DP_EXP_W{1'b1}}, m, {MAN_PAD{1'b0}}};
    end else if (e == '0) begin
      if (m == '0) begin
        r = {s, {(DP_W-1){1'b0}}};
      end else begin
        p  = lead_one(m);
        sh = {{(DP_MAN_W+1-SP_MAN_W){1'b0}}, m} << (DP_MAN_W - p);
        r  = {s, DP_EXP_W'(DENORM_BASE + p), sh[DP_MAN_W-1:0]};
      end
    end else begin
      r = {s, DP_EXP_W'(int'(e) + BIAS_DIFF), m, {MAN_PAD{1'b0}}};
    end
    return r;
  endfunction

  // Takes sign, full exponent and the top SP_MAN_W fraction bits only.
  function automatic logic [SP_W-1:0] narrow_dp(input logic [KEEP_W-1:0] k);
    logic                s;
    logic [DP_EXP_W-1:0] e;
    logic [SP_MAN_W-1:0] f;
    logic [SP_MAN_W:0]   t;
    logic [SP_W-1:0]     r;
    int                  ev;
    s  = k[KEEP_W-1];
    e  = k[KEEP_W-2:SP_MAN_W];
    f  = k[SP_MAN_W-1:0];
    ev = int'(e);
    if (e == '1) begin
      r = {s, {SP_EXP_W{1'b1}}, f};
    end else if (ev > SP_EXP_MAX + BIAS_DIFF) begin
      r = {s, {SP_EXP_W{1'b1}}, {SP_MAN_W{1'b0}}};
    end else if (ev > BIAS_DIFF) begin
      r = {s, SP_EXP_W'(ev - BIAS_DIFF), f};
    end else if (ev >= DENORM_BASE) begin
      t = {1'b1, f} >> (BIAS_DIFF + 1 - ev);
      r = {s, {SP_EXP_W{1'b0}}, t[SP_MAN_W-1:0]};
    end else begin
      r = {s, {(SP_W-1){1'b0}}};
    end
    return r;
  endfunction
endpackage

// File: rtl/fimm_field_merge.sv
module fimm_field_merge
  import fimm_pkg::*;
(
  input  logic [D0_W-1:0]  d0,
  input  logic [D1_W-1:0]  d1,
  input  logic [D2_W-1:0]  d2,
  output logic [IMM_W-1:0] imm
);
  // d0 is the most significant field, d2 the least.
  assign imm = {d0, d1, d2};
endmodule

// File: rtl/fimm_narrow.sv
module fimm_narrow
  import fimm_pkg::*;
(
  input  logic [DP_W-1:0] dp_in,
  output logic [SP_W-1:0] sp_out,
  output logic            ev_flush
);
  localparam int TOP_EXP_LSB = DP_MAN_W;
  logic [DP_EXP_W-1:0] dexp;
  logic                unused_frac_low;

  assign dexp     = dp_in[DP_W-2:TOP_EXP_LSB];
  assign sp_out   = narrow_dp(dp_in[DP_W-1:MAN_PAD]);
  assign ev_flush = (int'(dexp) < DENORM_BASE);
  assign unused_frac_low = ^dp_in[MAN_PAD-1:0];
endmodule

// File: rtl/fimm_widen.sv
module fimm_widen
  import fimm_pkg::*;
(
  input  logic [SP_W-1:0] sp_in,
  output logic [DP_W-1:0] dp_out,
  output logic            ev_special,
  output logic            ev_denorm
);
  logic [SP_EXP_W-1:0] sexp;
  logic [SP_MAN_W-1:0] sman;

  assign sexp       = sp_in[SP_W-2:SP_MAN_W];
  assign sman       = sp_in[SP_MAN_W-1:0];
  assign dp_out     = widen_sp(sp_in);
  assign ev_special = (sexp == '1);
  assign ev_denorm  = (sexp == '0) && (sman != '0);
endmodule

// File: rtl/fimm_builder.sv
module fimm_builder
  import fimm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              op_sel,
  input  logic [D0_W-1:0]   imm_d0,
  input  logic [D1_W-1:0]   imm_d1,
  input  logic [D2_W-1:0]   imm_d2,
  input  logic [DP_W-1:0]   reg_in,
  output logic              res_we,
  output logic [DP_W-1:0]   res_data
);
  localparam int HALF_W = SP_W - IMM_W;

  logic [IMM_W-1:0] imm;
  logic [SP_W-1:0]  narrowed;
  logic [SP_W-1:0]  sp_src;
  logic [DP_W-1:0]  widened;
  logic             ev_flush;
  logic             ev_special;
  logic             ev_denorm;
  logic             is_insert;
  logic             unused_narrow_low;

  fimm_field_merge u_merge (
    .d0(imm_d0), .d1(imm_d1), .d2(imm_d2), .imm(imm)
  );

  fimm_narrow u_narrow (
    .dp_in(reg_in), .sp_out(narrowed), .ev_flush(ev_flush)
  );

  assign is_insert = (fimm_op_e'(op_sel) == OP_INSERT);
  assign sp_src    = is_insert ? {narrowed[SP_W-1:IMM_W], imm}
                               : {imm, {HALF_W{1'b0}}};
  assign unused_narrow_low = ^narrowed[IMM_W-1:0];

  fimm_widen u_widen (
    .sp_in(sp_src), .dp_out(widened),
    .ev_special(ev_special), .ev_denorm(ev_denorm)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_we   <= 1'b0;
      res_data <= '0;
    end else begin
      res_we <= in_valid;
      if (in_valid) res_data <= widened;
    end
  end

  AST_WE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_we); // R7
  AST_NO_SPURIOUS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_we); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res_data)); // R7
  AST_LOAD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_insert) |=> res_data[DP_W-1] == $past(imm_d0[D0_W-1])); // R1
  AST_LOW_FRAC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_data[MAN_PAD-1:0] == '0); // R2
  AST_SPECIAL_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_special) |=> res_data[DP_W-2:DP_MAN_W] == '1); // R3
  AST_DENORM_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_denorm) |=> res_data[DP_W-2:DP_MAN_W] != '0); // R4
  AST_INSERT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_insert) |=> res_data[DP_W-1] == $past(reg_in[DP_W-1])); // R5
  AST_FLUSH_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_insert && ev_flush)
      |=> int'(res_data[DP_W-2:DP_MAN_W]) <= BIAS_DIFF); // R6
endmodule

// File: tb/sim_fimm_builder.sv
`timescale 1ns/1ps
module sim_fimm_builder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        op_sel;
  logic [9:0]  imm_d0;
  logic [4:0]  imm_d1;
  logic [0:0]  imm_d2;
  logic [63:0] reg_in;
  logic        res_we;
  logic [63:0] res_data;

  always #2 clk = ~clk;

  fimm_builder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .imm_d0(imm_d0), .imm_d1(imm_d1), .imm_d2(imm_d2),
    .reg_in(reg_in), .res_we(res_we), .res_data(res_data)
  );

  typedef struct {
    logic [63:0] val;
    string       tag;
  } item_t;

  item_t sb[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Driver: one request per call, expected result queued.
  task automatic send(input bit op, input logic [15:0] imm,
                      input logic [63:0] rv, input logic [63:0] expv,
                      input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1;
    op_sel   = op;
    imm_d0   = imm[15:6];
    imm_d1   = imm[5:1];
    imm_d2   = imm[0];
    reg_in   = rv;
    it.val = expv;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: pops the scoreboard whenever the design strobes a result.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done && res_we === 1'b1) begin
      if (sb.size() == 0) begin
        check(1'b0, "R7 strobe with nothing pending", {63'b0, res_we}, 64'd0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(res_data === it.val, it.tag, res_data, it.val);
      end
    end
  end

  initial begin
    #(4 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", sb.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held;
    rst_n = 1'b0; in_valid = 1'b0; op_sel = 1'b0;
    imm_d0 = '0; imm_d1 = '0; imm_d2 = '0; reg_in = '0;
    repeat (3) @(negedge clk);
    check(res_we === 1'b0, "R8 reset write enable", {63'b0, res_we}, 64'd0);
    check(res_data === 64'd0, "R8 reset data", res_data, 64'd0);
    rst_n = 1'b1;
    idle(2);
    check(res_we === 1'b0, "R7 idle after reset", {63'b0, res_we}, 64'd0);

    // Loads of documented constants (R2, R3, R4)
    send(1'b0, 16'h3F80, 64'h0, 64'h3FF0_0000_0000_0000, "R2 load +1.0");
    send(1'b0, 16'hBF80, 64'h0, 64'hBFF0_0000_0000_0000, "R2 load -1.0");
    send(1'b0, 16'hBFC0, 64'h0, 64'hBFF8_0000_0000_0000, "R2 load -1.5");
    send(1'b0, 16'h3FFF, 64'h0, 64'h3FFF_E000_0000_0000, "R2 load 1.9921875");
    send(1'b0, 16'h0000, 64'h0, 64'h0000_0000_0000_0000, "R4 load +0.0");
    send(1'b0, 16'h8000, 64'h0, 64'h8000_0000_0000_0000, "R4 load -0.0");
    send(1'b0, 16'h7F80, 64'h0, 64'h7FF0_0000_0000_0000, "R3 load +inf");
    send(1'b0, 16'hFF80, 64'h0, 64'hFFF0_0000_0000_0000, "R3 load -inf");
    send(1'b0, 16'h7FC0, 64'h0, 64'h7FF8_0000_0000_0000, "R3 load quiet NaN");
    send(1'b0, 16'h0080, 64'h0, 64'h3810_0000_0000_0000, "R3 load smallest normal");
    // Field positions and denormal normalization (R1, R4)
    send(1'b0, 16'h0001, 64'h0, 64'h37A0_0000_0000_0000, "R1 d2 bit / R4 denormal p=16");
    send(1'b0, 16'h0002, 64'h0, 64'h37B0_0000_0000_0000, "R1 d1 lsb / R4 denormal p=17");
    send(1'b0, 16'h0040, 64'h0, 64'h3800_0000_0000_0000, "R1 d0 lsb / R4 denormal p=22");
    idle(2);

    // Insert operations (R5, R6)
    send(1'b1, 16'h8000, 64'h3FF0_0000_0000_0000, 64'h3FF0_1000_0000_0000, "R5 insert after +1.0");
    send(1'b1, 16'h1234, 64'h7FF8_0000_0000_0000, 64'h7FF8_0246_8000_0000, "R5 insert NaN payload");
    send(1'b1, 16'hFFFF, 64'hBFF8_0000_0000_0000, 64'hBFF8_1FFF_E000_0000, "R5 insert negative");
    send(1'b1, 16'h0001, 64'h37A0_0000_0000_0000, 64'h37A0_0010_0000_0000, "R5 insert denormal round trip");
    send(1'b1, 16'h0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, "R5 insert into zero");
    send(1'b1, 16'h8000, 64'h3FF0_0000_1FFF_FFFF, 64'h3FF0_1000_0000_0000, "R6 low 29 bits ignored");
    send(1'b1, 16'h0000, 64'h000F_0000_0000_0000, 64'h0000_0000_0000_0000, "R6 tiny register flushes");
    send(1'b1, 16'h0000, 64'h8000_0000_0000_1234, 64'h8000_0000_0000_0000, "R6 signed zero kept");
    idle(2);

    // Hold while idle (R7)
    held = res_data;
    idle(3);
    check(res_we === 1'b0, "R7 no strobe while idle", {63'b0, res_we}, 64'd0);
    check(res_data === held, "R7 data held while idle", res_data, held);
    check(sb.size() == 0, "R7 all results delivered", 64'(sb.size()), 64'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule